// File: doc/BRIEF.md
# Segmented String Transfer Address Generator

This block computes the two physical byte addresses used by each element of a string-style memory copy on a 16-bit segmented machine. A source segment, a destination segment, a source offset, a destination offset and an element count are loaded through a small write port. Each step request then yields one registered pair of 20-bit addresses. The source address is formed from the source segment and source offset, and the destination address from the destination segment and destination offset. After each step both offsets move by one element and the count drops by one.

A direction input sets whether the offsets walk upward or downward. A size input chooses byte or word elements. The size is latched when the count is written, which marks the start of an operation. A done output is high whenever no elements remain. A step request made with nothing left is ignored.

Top module: `strw_addr_gen`

## Requirements
- R1: Each address equals the 16-bit segment times 16 plus the 16-bit offset, truncated to 20 bits. Segment 1000h with offset F000h gives 1F000h. Segment 020Ah with offset 1BCDh gives 03C6Dh. Segment FFFFh with offset 0010h gives 00000h.
- R2: `src_addr` uses the source segment (select 0) with the source offset (select 2). `dst_addr` uses the destination segment (select 1) with the destination offset (select 3).
- R3: After a performed step, both offsets increase by the stride when `dir_flag` is 0 and decrease by it when `dir_flag` is 1. Offset arithmetic wraps modulo 2^16, so an address never leaves its segment's 64 KB window.
- R4: The stride is 1 when `word_mode` was 0 at the last count write and 2 when it was 1. Changes to `word_mode` at any other time have no effect.
- R5: The count (select 4) drops by one on each performed step. `done` is high exactly when the count is zero.
- R6: A step request while the count is zero performs nothing. `addr_valid` stays low, and the offsets and the count keep their values.
- R7: The addresses are registered. They appear, with `addr_valid` high for one cycle, on the clock edge that follows the edge that sampled the step request.
- R8: A write stores `wr_data` into the register named by `wr_sel`. Selects 5 to 7 change nothing. A step request in the same cycle as any write is not performed.
- R9: After reset, all registers are zero, `addr_valid` is low, both addresses are zero and `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 src seg, 1 dst seg, 2 src offset, 3 dst offset, 4 count |
| wr_data | input | 16 | Write data |
| dir_flag | input | 1 | 0 walk upward, 1 walk downward |
| word_mode | input | 1 | Element size, latched on count write: 0 byte, 1 word |
| step_req | input | 1 | Request one element transfer |
| src_addr | output | 20 | Physical source address |
| dst_addr | output | 20 | Physical destination address |
| addr_valid | output | 1 | Addresses valid for this cycle |
| done | output | 1 | No elements remain |

## Verification
The assertions check four things on every cycle. A valid pulse only ever follows an accepted step. An idle step leaves the done state in place and produces no pulse. Each accepted step lowers the count by one and moves the source offset by the latched stride in the chosen direction. Done can fall only after a write.

Only the bench scenarios can show that the address arithmetic matches the segment-times-sixteen rule, including both 20-bit and 16-bit wraparound. The same applies to the destination channel using its own segment and offset, the latching of the size at count load, and the effect of ignored selects and of write/step collisions on later addresses.

// File: rtl/strw_pkg.sv
package strw_pkg;
  localparam int SEG_W   = 16;
  localparam int OFS_W   = 16;
  localparam int SHIFT   = 4;
  localparam int ADDR_W  = SEG_W + SHIFT;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = 3;
  localparam int NUM_PTR = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_SRC_SEG = 3'd0,
    SEL_DST_SEG = 3'd1,
    SEL_SRC_OFS = 3'd2,
    SEL_DST_OFS = 3'd3,
    SEL_COUNT   = 3'd4
  } wsel_e;

  // segment * 16 + offset, wrapped to ADDR_W bits
  function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFS_W-1:0] ofs);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ext;
    base = {seg, {SHIFT{1'b0}}};
    ext  = ADDR_W'(ofs);
    return base + ext;
  endfunction

  // offset advance by 1 or 2, wrapped within the segment
  function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] ofs,
                                                input logic down,
                                                input logic word);
    logic [OFS_W-1:0] step;
    step = word ? OFS_W'(2) : OFS_W'(1);
    return down ? (ofs - step) : (ofs + step);
  endfunction
endpackage

// File: rtl/strw_regfile.sv
module strw_regfile
  import strw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             step_fire,
  input  logic             dir_flag,
  input  logic             word_mode,
  output logic [SEG_W-1:0] src_seg,
  output logic [SEG_W-1:0] dst_seg,
  output logic [OFS_W-1:0] src_ofs,
  output logic [OFS_W-1:0] dst_ofs,
  output logic [CNT_W-1:0] count,
  output logic             stride_word
);
  logic [SEG_W-1:0] ptr_q [NUM_PTR];

  // Segments (0,1) hold; offsets (2,3) advance on a performed step
  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    localparam bit IS_OFS = (k >= 2);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[k] <= '0;
      end else if (wr_en && wr_sel == SEL_W'(k)) begin
        ptr_q[k] <= wr_data;
      end else if (IS_OFS && step_fire) begin
        ptr_q[k] <= next_ofs(ptr_q[k], dir_flag, stride_word);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      stride_word <= 1'b0;
    end else if (wr_en && wr_sel == SEL_COUNT) begin
      count       <= CNT_W'(wr_data);
      stride_word <= word_mode;
    end else if (step_fire) begin
      count       <= count - CNT_W'(1);
    end
  end

  assign src_seg = ptr_q[SEL_SRC_SEG];
  assign dst_seg = ptr_q[SEL_DST_SEG];
  assign src_ofs = ptr_q[SEL_SRC_OFS];
  assign dst_ofs = ptr_q[SEL_DST_OFS];
endmodule

// File: rtl/strw_addr_unit.sv
module strw_addr_unit
  import strw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [SEG_W-1:0]  seg_a,
  input  logic [OFS_W-1:0]  ofs_a,
  input  logic [SEG_W-1:0]  seg_b,
  input  logic [OFS_W-1:0]  ofs_b,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic              valid
);
  logic [SEG_W-1:0]  seg_v  [2];
  logic [OFS_W-1:0]  ofs_v  [2];
  logic [ADDR_W-1:0] addr_q [2];

  assign seg_v[0] = seg_a;
  assign seg_v[1] = seg_b;
  assign ofs_v[0] = ofs_a;
  assign ofs_v[1] = ofs_b;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q[c] <= '0;
      else if (fire) addr_q[c] <= phys_addr(seg_v[c], ofs_v[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= fire;
  end

  assign addr_a = addr_q[0];
  assign addr_b = addr_q[1];
endmodule

// File: rtl/strw_addr_gen.sv
module strw_addr_gen
  import strw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              dir_flag,
  input  logic              word_mode,
  input  logic              step_req,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              addr_valid,
  output logic              done
);
  logic [SEG_W-1:0] src_seg, dst_seg;
  logic [OFS_W-1:0] src_ofs, dst_ofs;
  logic [CNT_W-1:0] cnt_q;
  logic             stride_word;
  logic             cnt_zero;
  logic             step_fire;

  assign cnt_zero  = (cnt_q == '0);
  assign step_fire = step_req && !wr_en && !cnt_zero;
  assign done      = cnt_zero;

  strw_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .step_fire   (step_fire),
    .dir_flag    (dir_flag),
    .word_mode   (word_mode),
    .src_seg     (src_seg),
    .dst_seg     (dst_seg),
    .src_ofs     (src_ofs),
    .dst_ofs     (dst_ofs),
    .count       (cnt_q),
    .stride_word (stride_word)
  );

  strw_addr_unit u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (step_fire),
    .seg_a  (src_seg),
    .ofs_a  (src_ofs),
    .seg_b  (dst_seg),
    .ofs_b  (dst_ofs),
    .addr_a (src_addr),
    .addr_b (dst_addr),
    .valid  (addr_valid)
  );
endmodule

// File: rtl/strw_addr_gen_chk.sv
module strw_addr_gen_chk
  import strw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             step_req,
  input logic             dir_flag,
  input logic             done,
  input logic             addr_valid,
  input logic             step_fire,
  input logic [CNT_W-1:0] cnt_q,
  input logic [OFS_W-1:0] src_ofs,
  input logic             stride_word
);
  // R7: a valid pulse only follows an accepted step request
  assert_valid_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(step_req && !wr_en && !done));

  // R6: idle step keeps done and produces no pulse
  assert_idle_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !wr_en && done) |=> (!addr_valid && done));

  // R5: performed step lowers the count by one
  assert_count_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));

  // R3: upward walk by the latched stride
  assert_ofs_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !dir_flag) |=>
      src_ofs == OFS_W'($past(src_ofs) + ($past(stride_word) ? OFS_W'(2) : OFS_W'(1))));

  // R3: downward walk by the latched stride
  assert_ofs_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && dir_flag) |=>
      src_ofs == OFS_W'($past(src_ofs) - ($past(stride_word) ? OFS_W'(2) : OFS_W'(1))));

  // R8: done can only fall after a write
  assert_done_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(wr_en));
endmodule

bind strw_addr_gen strw_addr_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .step_req    (step_req),
  .dir_flag    (dir_flag),
  .done        (done),
  .addr_valid  (addr_valid),
  .step_fire   (step_fire),
  .cnt_q       (cnt_q),
  .src_ofs     (src_ofs),
  .stride_word (stride_word)
);

// File: tb/strw_addr_gen_bench.sv
module strw_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        dir_flag = 1'b0;
  logic        word_mode = 1'b0;
  logic        step_req = 1'b0;
  logic [19:0] src_addr, dst_addr;
  logic        addr_valid, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  strw_addr_gen u_strw_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dir_flag(dir_flag), .word_mode(word_mode), .step_req(step_req),
    .src_addr(src_addr), .dst_addr(dst_addr), .addr_valid(addr_valid), .done(done)
  );

  // {src seg, src ofs, dst seg, dst ofs, expected src, expected dst}
  localparam int NV = 4;
  localparam logic [103:0] VEC [NV] = '{
    {16'h1000, 16'hF000, 16'h020A, 16'h1BCD, 20'h1F000, 20'h03C6D},
    {16'hFFFF, 16'h0010, 16'h0000, 16'hFFFF, 20'h00000, 20'h0FFFF},
    {16'hABCD, 16'h1234, 16'h0001, 16'h0002, 20'hACF04, 20'h00012},
    {16'hF000, 16'hFFFF, 16'h8000, 16'h8000, 20'hFFFFF, 20'h88000}
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one step; result sampled at the following falling edge
  task automatic step();
    @(negedge clk);
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 done", 20'(done), 20'd1);
    check("R9 valid", 20'(addr_valid), 20'd0);
    check("R9 src", src_addr, 20'h0);
    rst_n = 1'b1;

    // R1 R2 vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VEC[i][103:88]);
      wr(3'd2, VEC[i][87:72]);
      wr(3'd1, VEC[i][71:56]);
      wr(3'd3, VEC[i][55:40]);
      wr(3'd4, 16'd1);
      check("R5 done low", 20'(done), 20'd0);
      step();
      check("R7 valid", 20'(addr_valid), 20'd1);
      check("R1 src", src_addr, VEC[i][39:20]);
      check("R2 dst", dst_addr, VEC[i][19:0]);
      check("R5 done high", 20'(done), 20'd1);
    end

    // R3 R4 upward word walk crossing offset wrap
    dir_flag = 1'b0; word_mode = 1'b1;
    wr(3'd0, 16'h0100); wr(3'd2, 16'hFFFE);
    wr(3'd1, 16'h0200); wr(3'd3, 16'h0001);
    wr(3'd4, 16'd3);
    step();
    check("R3 src1", src_addr, 20'h10FFE);
    check("R3 dst1", dst_addr, 20'h02001);
    check("R7 pulse ends", 20'(addr_valid), 20'd1);
    @(negedge clk);
    check("R7 pulse one cycle", 20'(addr_valid), 20'd0);
    step();
    check("R3 src wrap", src_addr, 20'h01000);
    check("R4 dst word", dst_addr, 20'h02003);
    step();
    check("R3 src3", src_addr, 20'h01002);
    check("R5 done after 3", 20'(done), 20'd1);
    // R6 idle step
    step();
    check("R6 no valid", 20'(addr_valid), 20'd0);
    check("R6 addr held", src_addr, 20'h01002);
    wr(3'd4, 16'd1);
    step();
    check("R6 ofs unchanged", src_addr, 20'h01004);
    check("R6 dst unchanged", dst_addr, 20'h02007);

    // R3 R4 downward byte walk; word_mode raised after count write is ignored
    dir_flag = 1'b1; word_mode = 1'b0;
    wr(3'd0, 16'h0000); wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0000); wr(3'd3, 16'h0005);
    wr(3'd4, 16'd2);
    word_mode = 1'b1;
    step();
    check("R3 down src1", src_addr, 20'h00000);
    check("R3 down dst1", dst_addr, 20'h00005);
    step();
    check("R3 down wrap", src_addr, 20'h0FFFF);
    check("R4 latched byte", dst_addr, 20'h00004);

    // R8 ignored select and write/step collision
    dir_flag = 1'b0; word_mode = 1'b0;
    wr(3'd0, 16'h0000); wr(3'd2, 16'h0040);
    wr(3'd1, 16'h0000); wr(3'd3, 16'h0080);
    wr(3'd4, 16'd2);
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd7; wr_data = 16'h1234; step_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; step_req = 1'b0;
    check("R8 collision no valid", 20'(addr_valid), 20'd0);
    step();
    check("R8 src untouched", src_addr, 20'h00040);
    check("R8 dst untouched", dst_addr, 20'h00080);
    check("R8 count kept", 20'(done), 20'd0);
    step();
    check("R8 second step", src_addr, 20'h00041);
    check("R8 done", 20'(done), 20'd1);

    finish_up();
  end
endmodule